// File: doc/BRIEF.md
# Interleaved Four-Bank Block Fetch Unit

This unit sits on the memory side of a cache and fills cache blocks from a set of independent word-wide banks. A block is one word from each bank. When a block request is taken, every bank starts its slow read in the same cycle. Once the shared bank access time has passed, the words leave over a one-word bus on consecutive cycles, in bank order. The long access time is therefore paid once per block and not once per word. With the defaults (four banks, 25-cycle access), a block fill takes 30 cycles from the request cycle to the last word: 1 cycle for the address, 25 for the banks, and 4 for the words. That is 16 bytes every 30 cycles.

Single-word writes go straight to one bank. The two lowest bits of the word address choose the bank, and the upper bits choose the row inside that bank. A write is taken in any cycle, including while a fill is in flight. The words of a fill are captured from the banks in the cycle the request is taken, so a later write never changes a block that is already on its way out.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `req_ready` is 1 and `rd_valid` and `rd_last` are 0.
- R2: A block request is taken in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle after the last word, when it returns to 1.
- R3: The first word of a block is valid exactly LAT+1 cycles after the request cycle (26 with defaults). The last word is valid LAT+NBANK cycles after it, so a block takes 30 cycles counting the request cycle.
- R4: Words come out on consecutive cycles with `rd_valid` high, in bank order 0 to NBANK-1. `rd_bank` gives the bank number. `rd_data` is the word at word address {req_addr, rd_bank}.
- R5: `rd_last` is 1 together with the word from bank NBANK-1, and 0 in every other cycle.
- R6: A write with `wr_valid` high stores `wr_data` only in bank `wr_addr[1:0]` at row `wr_addr[AW-1:2]`. Every other word keeps its value.
- R7: A fill returns the bank contents as they were when the request was taken. A write in the same cycle, or in any later cycle of the fill, is not visible in that fill, but it is visible in the next fill of that block.
- R8: A `req_valid` presented while `req_ready` is 0 is ignored. No further words follow the current block, and `req_ready` is 1 after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Block request strobe |
| req_addr | input | AW-2 | Block address (row in every bank) |
| req_ready | output | 1 | Unit can take a block request |
| wr_valid | input | 1 | Single-word write strobe |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | DW | Write data |
| rd_valid | output | 1 | Returned word valid |
| rd_bank | output | 2 | Bank number of the returned word |
| rd_data | output | DW | Returned word |
| rd_last | output | 1 | Last word of the block |

## Verification
A latency counter that is off by one moves the whole group of words by a cycle. This shows at the first word of the very next fill, 26 cycles after its request. A wrong return index shows up as a wrong bank number or the wrong data on the word where it happens. A missing end of the return state leaves `req_ready` low past cycle 30. A write routed to the wrong bank, or a capture taken at the wrong time, shows only when that block is next fetched. For this reason the bench writes in every bank, fills the same blocks again, and writes during fills.

// File: rtl/ilvf_pkg.sv
package ilvf_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } ilvf_state_t;
endpackage

// File: rtl/ilvf_bank.sv
module ilvf_bank #(
   parameter int DW = 32,
   parameter int RW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [RW-1:0] wr_row,
   input  logic [DW-1:0] wr_word,
   input  logic          cap_en,
   input  logic [RW-1:0] cap_row,
   output logic [DW-1:0] held_word
);
   localparam int ROWS = 1 << RW;

   logic [DW-1:0] cells [ROWS];

   always_ff @(posedge clk) begin
      if (wr_en) cells[wr_row] <= wr_word;
   end

   // capture reads the pre-write contents at the same edge
   always_ff @(posedge clk) begin
      if (!rst_n)      held_word <= '0;
      else if (cap_en) held_word <= cells[cap_row];
   end
endmodule

// File: rtl/ilvf_wr_route.sv
module ilvf_wr_route #(
   parameter int AW    = 6,
   parameter int NBANK = 4
) (
   input  logic                          wr_valid,
   input  logic [AW-1:0]                 wr_addr,
   output logic [NBANK-1:0]              bank_en,
   output logic [AW-$clog2(NBANK)-1:0]   row
);
   localparam int BW = $clog2(NBANK);

   assign row = wr_addr[AW-1:BW];

   for (genvar b = 0; b < NBANK; b++) begin : g_dec
      assign bank_en[b] = wr_valid && (wr_addr[BW-1:0] == BW'(b));
   end
endmodule

// File: rtl/ilvf_seq.sv
module ilvf_seq
   import ilvf_pkg::*;
#(
   parameter int NBANK = 4,
   parameter int LAT   = 25
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     req_valid,
   output logic                     req_ready,
   output logic                     start,
   output logic                     ret_valid,
   output logic [$clog2(NBANK)-1:0] ret_idx,
   output logic                     ret_last
);
   localparam int BW = $clog2(NBANK);
   localparam int CW = $clog2(LAT + 1);

   ilvf_state_t   state;
   logic [CW-1:0] wait_cnt;
   logic [BW-1:0] idx;

   assign req_ready = (state == ST_IDLE);
   assign start     = req_valid && req_ready;
   assign ret_valid = (state == ST_SEND);
   assign ret_idx   = idx;
   assign ret_last  = ret_valid && (idx == BW'(NBANK - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         wait_cnt <= '0;
         idx      <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_WAIT;
                  wait_cnt <= '0;
               end
            end
            ST_WAIT: begin
               if (wait_cnt == CW'(LAT - 1)) begin
                  state <= ST_SEND;
                  idx   <= '0;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            ST_SEND: begin
               if (idx == BW'(NBANK - 1)) state <= ST_IDLE;
               else                       idx   <= idx + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch #(
   parameter int DW    = 32,
   parameter int AW    = 6,
   parameter int NBANK = 4,
   parameter int LAT   = 25
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        req_valid,
   input  logic [AW-$clog2(NBANK)-1:0] req_addr,
   output logic                        req_ready,
   input  logic                        wr_valid,
   input  logic [AW-1:0]               wr_addr,
   input  logic [DW-1:0]               wr_data,
   output logic                        rd_valid,
   output logic [$clog2(NBANK)-1:0]    rd_bank,
   output logic [DW-1:0]               rd_data,
   output logic                        rd_last
);
   localparam int BW = $clog2(NBANK);
   localparam int RW = AW - BW;

   if (NBANK < 2 || (1 << BW) != NBANK) begin : g_bad_nbank
      $error("NBANK must be a power of two, at least 2");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end
   if (RW < 1) begin : g_bad_aw
      $error("AW must leave at least one row bit");
   end

   logic             start;
   logic [NBANK-1:0] bank_wr;
   logic [RW-1:0]    wr_row;
   logic [DW-1:0]    held [NBANK];

   ilvf_seq #(.NBANK(NBANK), .LAT(LAT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_ready (req_ready),
      .start     (start),
      .ret_valid (rd_valid),
      .ret_idx   (rd_bank),
      .ret_last  (rd_last)
   );

   ilvf_wr_route #(.AW(AW), .NBANK(NBANK)) u_route (
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .bank_en  (bank_wr),
      .row      (wr_row)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ilvf_bank #(.DW(DW), .RW(RW)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (bank_wr[b]),
         .wr_row    (wr_row),
         .wr_word   (wr_data),
         .cap_en    (start),
         .cap_row   (req_addr),
         .held_word (held[b])
      );
   end

   assign rd_data = rd_valid ? held[rd_bank] : '0;
endmodule

// File: rtl/ilv_block_fetch_chk.sv
module ilv_block_fetch_chk #(
   parameter int NBANK = 4,
   parameter int LAT   = 25
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic                     rd_valid,
   input logic [$clog2(NBANK)-1:0] rd_bank,
   input logic                     rd_last
);
   localparam int BW = $clog2(NBANK);
   localparam int GW = $clog2(LAT + 3);

   logic [GW-1:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n)                         gap <= '0;
      else if (req_valid && req_ready)    gap <= GW'(1);
      else if (gap != '0 && !rd_valid)    gap <= gap + 1'b1;
      else if (rd_valid)                  gap <= '0;
   end

   p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   p_no_ready_in_return_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !req_ready);

   p_ready_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |=> req_ready);

   p_first_word_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (gap == GW'(LAT + 1)));

   p_first_bank_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> (rd_bank == '0));

   p_bank_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_last) |=> (rd_valid && rd_bank == $past(rd_bank) + 1'b1));

   p_last_on_top_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> (rd_valid && rd_bank == BW'(NBANK - 1)));

   p_last_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |=> !rd_last);
endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(.NBANK(NBANK), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .rd_valid  (rd_valid),
   .rd_bank   (rd_bank),
   .rd_last   (rd_last)
);

// File: tb/ilv_block_fetch_test.sv
`timescale 1ns/1ps
module ilv_block_fetch_test;
   localparam int DW    = 32;
   localparam int AW    = 6;
   localparam int NBANK = 4;
   localparam int LAT   = 25;
   localparam int RW    = AW - 2;
   localparam int WORDS = 1 << AW;
   localparam int SPAN  = LAT + NBANK + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [RW-1:0] req_addr = '0;
   logic          req_ready;
   logic          wr_valid = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_valid;
   logic [1:0]    rd_bank;
   logic [DW-1:0] rd_data;
   logic          rd_last;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [DW-1:0] model [WORDS];

   always #2.5 clk = ~clk;

   ilv_block_fetch #(.DW(DW), .AW(AW), .NBANK(NBANK), .LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_bank(rd_bank),
      .rd_data(rd_data), .rd_last(rd_last)
   );

   function automatic logic [DW-1:0] expect_word(logic [DW-1:0] snap [NBANK], int j);
      return snap[j - (LAT + 1)];
   endfunction

   function automatic bit expect_valid(int j);
      return (j >= LAT + 1) && (j <= LAT + NBANK);
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected below 150000", cycles);
         summary();
      end
   end

   task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      model[a] = d;
      @(negedge clk);
      wr_valid = 1'b0;
   endtask

   // same_wr: write in request cycle; mid_wr: write during wait; busy_req: request while busy
   task automatic do_fill(logic [RW-1:0] blk, bit same_wr, bit mid_wr, bit busy_req);
      logic [DW-1:0] snap [NBANK];
      logic [AW-1:0] wa;
      @(negedge clk);
      chk(req_ready == 1'b1, "R2 ready before request", DW'(req_ready), 1);
      for (int i = 0; i < NBANK; i++) snap[i] = model[{blk, 2'(i)}];
      req_valid = 1'b1; req_addr = blk;
      if (same_wr) begin
         wa = {blk, 2'($urandom_range(0, 3))};
         wr_valid = 1'b1; wr_addr = wa; wr_data = $urandom;
         model[wa] = wr_data;
      end
      @(negedge clk);
      req_valid = 1'b0; wr_valid = 1'b0;
      for (int j = 1; j <= SPAN; j++) begin
         chk(req_ready == (j == SPAN), "R2 ready low until block ends", DW'(req_ready), DW'(j == SPAN));
         chk(rd_valid == expect_valid(j), "R3 word timing", DW'(rd_valid), DW'(expect_valid(j)));
         if (expect_valid(j)) begin
            chk(rd_bank == 2'(j - (LAT + 1)), "R4 bank order", DW'(rd_bank), DW'(j - (LAT + 1)));
            chk(rd_data == expect_word(snap, j), "R4 R6 R7 returned data", rd_data, expect_word(snap, j));
         end
         chk(rd_last == (j == LAT + NBANK), "R5 last strobe", DW'(rd_last), DW'(j == LAT + NBANK));
         if (j == SPAN) break;
         if (mid_wr && j == 10) begin
            wa = {blk, 2'($urandom_range(0, 3))};
            wr_valid = 1'b1; wr_addr = wa; wr_data = $urandom;
            model[wa] = wr_data;
         end
         if (mid_wr && j == 11) wr_valid = 1'b0;
         if (busy_req && j == 5) begin
            req_valid = 1'b1; req_addr = blk + 1'b1;
         end
         if (busy_req && j == LAT + NBANK) req_valid = 1'b0;
         @(negedge clk);
      end
      if (busy_req) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(rd_valid == 1'b0, "R8 busy request ignored", DW'(rd_valid), 0);
            chk(req_ready == 1'b1, "R8 ready stays high", DW'(req_ready), 1);
         end
      end
   endtask

   initial begin
      int seed_init;
      seed_init = $urandom(1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1 reset ready", DW'(req_ready), 1);
      chk(rd_valid == 1'b0, "R1 reset valid", DW'(rd_valid), 0);
      chk(rd_last == 1'b0, "R1 reset last", DW'(rd_last), 0);

      for (int a = 0; a < WORDS; a++) do_write(AW'(a), $urandom);

      // directed corner cases
      do_fill('0, 1'b0, 1'b0, 1'b0);
      do_fill('1, 1'b0, 1'b0, 1'b0);
      do_fill(RW'(3), 1'b1, 1'b0, 1'b0);  // R7 same-cycle write
      do_fill(RW'(3), 1'b0, 1'b0, 1'b0);  // R7 now visible
      do_fill(RW'(5), 1'b0, 1'b1, 1'b0);  // R7 write mid-fill
      do_fill(RW'(5), 1'b0, 1'b0, 1'b0);
      do_fill(RW'(7), 1'b0, 1'b0, 1'b1);  // R8 busy request
      do_write({RW'(7), 2'd2}, 32'hA5A5_0F0F);  // R6 single-word write
      do_fill(RW'(7), 1'b0, 1'b0, 1'b0);

      // constrained random mix
      for (int n = 0; n < 30; n++) begin
         if ($urandom_range(0, 1) == 1) do_write(AW'($urandom_range(0, WORDS - 1)), $urandom);
         do_fill(RW'($urandom_range(0, (1 << RW) - 1)),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, $urandom_range(0, 4) == 0);
      end
      summary();
   end
endmodule